// File: doc/BRIEF.md
# Host-to-Processor Byte Mailbox Channel

This block is one channel of a byte-wide mailbox between an external host bus and an internal processor bus. The host sees a chip select, one address line, separate read and write strobes and an 8-bit data path. A host write loads an inbound byte. A host read returns either the outbound byte or a status byte, depending on the address line. The internal processor reaches the same state through a small single-cycle register bus. On that bus it takes the inbound byte, supplies the outbound byte, and reads or updates the status byte.

Two flags carry the handshake. The inbound-full flag rises when the host deposits a byte and falls when the processor collects it. The outbound-full flag rises when the processor supplies a byte and falls when the host fetches it. On every host write, the level of the host address line is latched into the status byte. The processor can therefore tell a command byte from a data byte. Five further status bits belong to software: the processor sets them and the host can only observe them. A hardware standby input clears the whole status byte, and leaves the outbound byte untouched.

The host strobes, address and data are brought into the processor clock domain through a synchroniser chain. Each strobe acts once, on its active edge. The host data bus is driven only while a read is in progress, through a separate output-enable signal.

Top module: `hostif_mailbox`

## Requirements
- R1: After reset the status byte reads 0x00 on the processor bus, and host_oe is low while no host read is active.
- R2: host_oe is high exactly while host_cs_n and host_rd_n are both low. With host_a0 low, host_dout carries the outbound byte last written by the processor.
- R3: A host read with host_a0 high returns the status byte and changes no flag. Status layout: bits 7..4 and bit 2 are software bits, bit 3 is the command flag, bit 1 is inbound-full, bit 0 is outbound-full.
- R4: A host write, meaning host_cs_n and host_wr_n both low, loads host_din into the inbound byte whatever the level of host_a0. The processor reads that byte at bus address 0.
- R5: On each host write, status bit 3 takes the level of host_a0: 0 marks data and 1 marks a command.
- R6: A host write sets status bit 1. A processor read of address 0 clears it.
- R7: A processor write to address 1 stores the outbound byte and sets status bit 0. A host read with host_a0 low clears status bit 0.
- R8: A processor write to address 2 updates status bits 7..4 and 2 and leaves bits 3, 1 and 0 unchanged. A processor read of address 2 returns the status byte.
- R9: While standby_i is high at a clock edge, the status byte becomes 0x00. The outbound byte keeps its value.
- R10: A host strobe held active acts only once. If the processor clears inbound-full while a host write strobe is still held, the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Hardware standby; clears the status byte |
| host_cs_n | input | 1 | Host chip select, active low |
| host_a0 | input | 1 | Host address line: status/command select |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_oe | output | 1 | Output enable for the host data bus |
| slv_sel | input | 1 | Processor bus access strobe, one cycle per access |
| slv_we | input | 1 | Processor bus write when high, read when low |
| slv_addr | input | 2 | 0 inbound byte, 1 outbound byte, 2 status, 3 unused |
| slv_wdata | input | 8 | Processor write data |
| slv_rdata | output | 8 | Processor read data |

## Verification
The assertions assume that each processor bus access lasts one cycle and that host strobes are slow next to the processor clock. A strobe is taken to stay active, and then inactive, for longer than the synchroniser depth, so that each edge yields one update. They also assume that host_a0 and host_din are steady while a strobe is active. The bench moves its host signals only on falling clock edges and holds every strobe phase for several cycles beyond the synchroniser latency. It raises slv_sel for a single cycle per access, so the stimulus never steps outside these assumptions.

// File: rtl/hif_pkg.sv
package hif_pkg;

    localparam int BYTE_W = 8;

    // status bit positions (behavioural: host and processor both decode these)
    localparam int ST_OBF = 0;
    localparam int ST_IBF = 1;
    localparam int ST_CD  = 3;
    localparam logic [BYTE_W-1:0] ST_SW_MASK = 8'hF4;

    typedef enum logic [1:0] {
        SA_INBOUND  = 2'd0,
        SA_OUTBOUND = 2'd1,
        SA_STATUS   = 2'd2,
        SA_SPARE    = 2'd3
    } slv_addr_e;

    typedef struct packed {
        logic [3:0] sw_hi;
        logic       cmd;
        logic       sw_b2;
        logic       in_full;
        logic       out_full;
    } status_t;

    typedef struct packed {
        logic [BYTE_W-1:0] inbound;
        logic [BYTE_W-1:0] outbound;
    } mbox_data_t;

endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= RST_VAL;
                end else begin
                    chain_q[g] <= chain_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/hif_strobe.sv
module hif_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic rd_n_s,
    input  logic wr_n_s,
    input  logic a0_s,
    output logic wr_pulse,
    output logic rd_out_pulse
);

    typedef struct packed {
        logic rd_act;
        logic wr_act;
    } strobe_state_t;

    strobe_state_t st_d, st_q;
    logic rd_now, wr_now;

    always_comb begin
        rd_now       = !cs_n_s && !rd_n_s;
        wr_now       = !cs_n_s && !wr_n_s;
        st_d.rd_act  = rd_now;
        st_d.wr_act  = wr_now;
        wr_pulse     = wr_now && !st_q.wr_act;
        rd_out_pulse = rd_now && !st_q.rd_act && !a0_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hif_regs.sv
module hif_regs
    import hif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              wr_pulse,
    input  logic              rd_out_pulse,
    input  logic              a0_s,
    input  logic [BYTE_W-1:0] din_s,
    input  logic              slv_sel,
    input  logic              slv_we,
    input  logic [1:0]        slv_addr,
    input  logic [BYTE_W-1:0] slv_wdata,
    output logic [BYTE_W-1:0] slv_rdata,
    output logic [BYTE_W-1:0] status_o,
    output logic [BYTE_W-1:0] outbound_o
);

    status_t    st_d, st_q;
    mbox_data_t dat_d, dat_q;
    logic       slv_rd, slv_wr;
    slv_addr_e  addr;

    always_comb begin
        addr   = slv_addr_e'(slv_addr);
        slv_rd = slv_sel && !slv_we;
        slv_wr = slv_sel && slv_we;
        st_d   = st_q;
        dat_d  = dat_q;

        // clearing events first, so that a coincident set wins
        if (slv_rd && addr == SA_INBOUND) begin
            st_d.in_full = 1'b0;
        end
        if (rd_out_pulse) begin
            st_d.out_full = 1'b0;
        end

        if (slv_wr && addr == SA_OUTBOUND) begin
            dat_d.outbound = slv_wdata;
            st_d.out_full  = 1'b1;
        end
        if (slv_wr && addr == SA_STATUS) begin
            st_d = status_t'((BYTE_W'(st_d) & ~ST_SW_MASK) | (slv_wdata & ST_SW_MASK));
        end

        if (wr_pulse) begin
            dat_d.inbound = din_s;
            st_d.cmd      = a0_s;
            st_d.in_full  = 1'b1;
        end

        if (standby_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // data bytes carry no reset value
    always_ff @(posedge clk) begin
        dat_q <= dat_d;
    end

    always_comb begin
        unique case (addr)
            SA_INBOUND:  slv_rdata = dat_q.inbound;
            SA_OUTBOUND: slv_rdata = dat_q.outbound;
            SA_STATUS:   slv_rdata = BYTE_W'(st_q);
            default:     slv_rdata = '0;
        endcase
    end

    assign status_o   = BYTE_W'(st_q);
    assign outbound_o = dat_q.outbound;

endmodule

// File: rtl/hostif_mailbox.sv
module hostif_mailbox
    import hif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              host_cs_n,
    input  logic              host_a0,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic              host_oe,
    input  logic              slv_sel,
    input  logic              slv_we,
    input  logic [1:0]        slv_addr,
    input  logic [BYTE_W-1:0] slv_wdata,
    output logic [BYTE_W-1:0] slv_rdata
);

    localparam int HW = BYTE_W + 4;
    localparam logic [HW-1:0] HRST = {3'b111, 1'b0, {BYTE_W{1'b0}}};

    logic [HW-1:0]     host_raw, host_s;
    logic              cs_n_s, rd_n_s, wr_n_s, ha0_s;
    logic [BYTE_W-1:0] din_s;
    logic              hwr_pulse, hrd_out_pulse;
    logic [BYTE_W-1:0] status_w, outbound_w;

    assign host_raw = {host_cs_n, host_rd_n, host_wr_n, host_a0, host_din};

    hif_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (HW),
        .RST_VAL(HRST)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(host_raw),
        .sync_o (host_s)
    );

    assign {cs_n_s, rd_n_s, wr_n_s, ha0_s, din_s} = host_s;

    hif_strobe u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (cs_n_s),
        .rd_n_s      (rd_n_s),
        .wr_n_s      (wr_n_s),
        .a0_s        (ha0_s),
        .wr_pulse    (hwr_pulse),
        .rd_out_pulse(hrd_out_pulse)
    );

    hif_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby_i),
        .wr_pulse    (hwr_pulse),
        .rd_out_pulse(hrd_out_pulse),
        .a0_s        (ha0_s),
        .din_s       (din_s),
        .slv_sel     (slv_sel),
        .slv_we      (slv_we),
        .slv_addr    (slv_addr),
        .slv_wdata   (slv_wdata),
        .slv_rdata   (slv_rdata),
        .status_o    (status_w),
        .outbound_o  (outbound_w)
    );

    // host bus path is combinational from the pins for bus timing
    assign host_oe   = !host_cs_n && !host_rd_n;
    assign host_dout = host_a0 ? status_w : outbound_w;

endmodule

// File: rtl/hif_checker.sv
module hif_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       standby_i,
    input logic       host_oe,
    input logic       host_a0,
    input logic [7:0] host_dout,
    input logic       slv_sel,
    input logic       slv_we,
    input logic [1:0] slv_addr,
    input logic [7:0] slv_wdata,
    input logic [7:0] status_w,
    input logic       hwr_pulse,
    input logic       ha0_s
);

    // R9
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> status_w == 8'h00);

    // R3
    status_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_oe && host_a0) |-> host_dout == status_w);

    // R6
    in_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hwr_pulse && !standby_i) |=> status_w[1]);

    // R5
    cmd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hwr_pulse && !standby_i) |=> status_w[3] == $past(ha0_s));

    // R7
    out_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_sel && slv_we && slv_addr == 2'd1 && !standby_i) |=> status_w[0]);

    // R8
    sw_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_sel && slv_we && slv_addr == 2'd2 && !standby_i) |=>
        (status_w[7:4] == $past(slv_wdata[7:4]) && status_w[2] == $past(slv_wdata[2])));

endmodule

bind hostif_mailbox hif_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby_i(standby_i),
    .host_oe  (host_oe),
    .host_a0  (host_a0),
    .host_dout(host_dout),
    .slv_sel  (slv_sel),
    .slv_we   (slv_we),
    .slv_addr (slv_addr),
    .slv_wdata(slv_wdata),
    .status_w (status_w),
    .hwr_pulse(hwr_pulse),
    .ha0_s    (ha0_s)
);

// File: tb/tb_hostif_mailbox.sv
module tb_hostif_mailbox;

    localparam int STG  = 2;
    localparam int HOLD = STG + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_i = 1'b0;
    logic       host_cs_n = 1'b1, host_a0 = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [7:0] host_din = '0;
    logic [7:0] host_dout;
    logic       host_oe;
    logic       slv_sel = 1'b0, slv_we = 1'b0;
    logic [1:0] slv_addr = '0;
    logic [7:0] slv_wdata = '0;
    logic [7:0] slv_rdata;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // bench model of the hardware status bits
    logic       m_cmd = 1'b0, m_in = 1'b0, m_out = 1'b0;
    logic [7:0] m_sw  = 8'h00;

    always #2ns clk = ~clk;

    hostif_mailbox #(.SYNC_STAGES(STG)) dut (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i),
        .host_cs_n(host_cs_n), .host_a0(host_a0), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .host_din(host_din), .host_dout(host_dout),
        .host_oe(host_oe), .slv_sel(slv_sel), .slv_we(slv_we),
        .slv_addr(slv_addr), .slv_wdata(slv_wdata), .slv_rdata(slv_rdata)
    );

    function automatic logic [7:0] exp_status();
        return (m_sw & 8'hF4) | {4'b0, m_cmd, 1'b0, m_in, m_out};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic slv_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        slv_sel = 1'b1; slv_we = 1'b1; slv_addr = a; slv_wdata = d;
        @(negedge clk);
        slv_sel = 1'b0; slv_we = 1'b0;
    endtask

    task automatic slv_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        slv_sel = 1'b1; slv_we = 1'b0; slv_addr = a;
        #1ns d = slv_rdata;
        @(negedge clk);
        slv_sel = 1'b0;
    endtask

    task automatic host_wr(input logic a0, input logic [7:0] d);
        @(negedge clk);
        host_a0 = a0; host_din = d; host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (HOLD) @(posedge clk);
        @(negedge clk);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        repeat (HOLD) @(posedge clk);
    endtask

    task automatic host_rd(input logic a0, output logic [7:0] d, output logic oe);
        @(negedge clk);
        host_a0 = a0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        #1ns d = host_dout; oe = host_oe;
        repeat (HOLD) @(posedge clk);
        @(negedge clk);
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        repeat (HOLD) @(posedge clk);
    endtask

    initial begin
        #800us;
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic       oe;

        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 reset state
        slv_rd(2'd2, rd);
        check(rd == 8'h00, "R1 status after reset", rd, 0);
        #1ns check(host_oe == 1'b0, "R1 oe idle", host_oe, 0);

        // R4 R5 R6: every inbound byte, address line taken from bit 0
        for (int v = 0; v < 256; v++) begin
            host_wr(v[0], 8'(v));
            m_cmd = v[0]; m_in = 1'b1;
            slv_rd(2'd2, rd);
            check(rd == exp_status(), "R5 R6 status after host write", rd, exp_status());
            slv_rd(2'd0, rd);
            check(rd == 8'(v), "R4 inbound byte", rd, v);
            m_in = 1'b0;
            slv_rd(2'd2, rd);
            check(rd[1] == 1'b0, "R6 inbound-full cleared", rd[1], 0);
        end

        // R2 R3 R7: every outbound byte
        for (int v = 0; v < 256; v++) begin
            slv_wr(2'd1, 8'(v));
            m_out = 1'b1;
            host_rd(1'b1, rd, oe);
            check(oe && rd == exp_status(), "R3 status on host bus", rd, exp_status());
            host_rd(1'b0, rd, oe);
            check(oe && rd == 8'(v), "R2 outbound on host bus", rd, v);
            m_out = 1'b0;
            slv_rd(2'd2, rd);
            check(rd == exp_status(), "R7 outbound-full cleared by host read", rd, exp_status());
        end

        // R8: every software-bit pattern, hardware bits must not move
        host_wr(1'b1, 8'h3C); m_cmd = 1'b1; m_in = 1'b1;
        slv_wr(2'd1, 8'hA5);  m_out = 1'b1;
        for (int v = 0; v < 256; v++) begin
            slv_wr(2'd2, 8'(v));
            m_sw = 8'(v);
            slv_rd(2'd2, rd);
            check(rd == exp_status(), "R8 software bits", rd, exp_status());
        end
        host_rd(1'b1, rd, oe);
        check(rd == exp_status(), "R8 host sees software bits", rd, exp_status());

        // R10: held write strobe acts once
        @(negedge clk);
        host_a0 = 1'b0; host_din = 8'h77; host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (HOLD) @(posedge clk);
        m_cmd = 1'b0; m_in = 1'b1;
        slv_rd(2'd0, rd);
        check(rd == 8'h77, "R10 inbound while held", rd, 8'h77);
        m_in = 1'b0;
        repeat (HOLD) @(posedge clk);
        slv_rd(2'd2, rd);
        check(rd[1] == 1'b0, "R10 inbound-full stays clear", rd[1], 0);
        @(negedge clk);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        repeat (HOLD) @(posedge clk);
        slv_rd(2'd2, rd);
        check(rd == exp_status(), "R10 after release", rd, exp_status());

        // R9: standby clears status, outbound byte kept
        slv_wr(2'd1, 8'h5A); m_out = 1'b1;
        @(negedge clk) standby_i = 1'b1;
        @(negedge clk) standby_i = 1'b0;
        m_cmd = 1'b0; m_in = 1'b0; m_out = 1'b0; m_sw = 8'h00;
        slv_rd(2'd2, rd);
        check(rd == 8'h00, "R9 status after standby", rd, 0);
        slv_rd(2'd1, rd);
        check(rd == 8'h5A, "R9 outbound kept", rd, 8'h5A);
        host_rd(1'b0, rd, oe);
        check(rd == 8'h5A, "R9 outbound on host bus", rd, 8'h5A);
        #1ns check(host_oe == 1'b0, "R2 oe released", host_oe, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule